// File: doc/BRIEF.md
# Block-Mode DMA Transfer Sequencer

This block is a single-channel DMA engine that works one block at a time. Software loads a source address, a destination address, a total byte count, a block length in elements, an element width, an increment enable for each side and a block-area select for each side, and then starts the channel. Each request pulse on `req` moves exactly one block of elements. Each element is a read from the source followed by a write to the destination, over a simple bus with a ready handshake.

While a block runs, `hold` tells an external arbiter to keep other channels waiting. The bus is released in the cycle after the last write of the block. `blk_end` marks the write that carries the last element of each block, and `ack` answers each accepted request once. A side marked as a block area returns to its programmed start address after every block. An unmarked side keeps advancing. An optional per-block interrupt can be enabled. A transfer-done interrupt fires when the total count runs out, even partway through a block. A request that arrives during a block is remembered and served when the block ends.

Top module: `blkdma_seq`

## Requirements
- R1: A `cfg_start` pulse while no block is running loads all `cfg_*` inputs and sets `busy`. A `cfg_start` pulse while `hold` is high is ignored, and the running transfer keeps its old addresses.
- R2: Each accepted request causes `ack` to pulse for one cycle and moves exactly `cfg_blk` elements. Each element is a read of the source address, then a write of the data read to the destination address.
- R3: `hold` rises in the cycle after `ack` and stays high for the whole block. It falls in the cycle after the write handshake of the last element.
- R4: The element width code is `cfg_size`: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes. After each element, a side whose increment enable is 1 advances by that byte count. A side whose increment enable is 0 keeps its address.
- R5: When `cfg_src_area` is 1, the source address returns to its programmed start after every block.
- R6: When `cfg_dst_area` is 1, the destination address returns to its programmed start after every block, while the source keeps advancing.
- R7: When neither area select is set, the next block continues both addresses from where the previous block stopped.
- R8: `blk_end` is high for exactly one cycle per block: the cycle of the write handshake of the block's last element.
- R9: `irq_blk` pulses together with `blk_end` when `cfg_blk_irq_en` is 1, and never pulses when it is 0.
- R10: The total counter drops by the element byte count after each write. On the write that brings it to zero, `irq_done` pulses, `busy` clears and `hold` falls, even partway through a block. After that, requests get no `ack` and cause no bus access.
- R11: A request that arrives while a block is running is latched. It is acknowledged and served once the current block ends, with no further request needed.
- R12: While `bus_valid` is high and `bus_ready` is low, `bus_addr` and `bus_write` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Load configuration and enable the channel |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_total | input | TW | Total transfer size in bytes |
| cfg_blk | input | BW | Block length in elements |
| cfg_size | input | 2 | Element width code (00 byte, 01 16-bit, 10 32-bit) |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| cfg_src_area | input | 1 | Source side is a block area |
| cfg_dst_area | input | 1 | Destination side is a block area |
| cfg_blk_irq_en | input | 1 | Per-block interrupt enable |
| req | input | 1 | Transfer request pulse |
| ack | output | 1 | Request accepted pulse |
| hold | output | 1 | Block in progress, hold other channels |
| busy | output | 1 | Channel enabled |
| blk_end | output | 1 | Last element of block is being written |
| irq_blk | output | 1 | Per-block interrupt pulse |
| irq_done | output | 1 | Transfer-done interrupt pulse |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access width code |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access completes this cycle |

## Verification
A wrong block counter shows up in the first block as a `blk_end` on the wrong write, or as `hold` falling one element early or late. A stale or wrong start register only shows on the second block, when a block-area side fails to return. A bad step value shows on the second element address. A total counter that is off leaves `busy` set, or clears it one write from the expected point. A request latch that is lost shows as a missing second `ack` after a block ends. So the directed tests always run at least two blocks and compare every logged address.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} blkdma_st_e;

  // element width code -> bytes per element
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/blkdma_addr.sv
module blkdma_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          inc_en,
  input  logic [2:0]    bytes,
  input  logic          restore,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      start_q <= '0;
    end else if (load) begin
      cur     <= load_val;
      start_q <= load_val;
    end else if (restore) begin
      cur <= start_q;
    end else if (step && inc_en) begin
      cur <= cur + AW'(bytes);
    end
  end
endmodule

// File: rtl/blkdma_cnt.sv
module blkdma_cnt #(
  parameter int TW = 32,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] total_val,
  input  logic [BW-1:0] blk_val,
  input  logic          blk_start,
  input  logic          step,
  input  logic [2:0]    bytes,
  output logic          total_last,
  output logic          blk_last
);
  localparam int BCW = BW + 1;

  logic [TW-1:0]  total_q;
  logic [BW-1:0]  blk_sz_q;
  logic [BCW-1:0] blk_left_q;
  logic [BCW-1:0] blk_reload;

  // a zero block length stands for the full 2^BW elements
  assign blk_reload = (blk_sz_q == '0) ? (BCW'(1) << BW) : {1'b0, blk_sz_q};
  assign total_last = (total_q <= TW'(bytes));
  assign blk_last   = (blk_left_q == BCW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q    <= '0;
      blk_sz_q   <= '0;
      blk_left_q <= '0;
    end else if (load) begin
      total_q  <= total_val;
      blk_sz_q <= blk_val;
    end else begin
      if (blk_start) blk_left_q <= blk_reload;
      else if (step) blk_left_q <= blk_left_q - BCW'(1);
      if (step) total_q <= total_last ? '0 : total_q - TW'(bytes);
    end
  end
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
  import blkdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 32,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [TW-1:0] cfg_total,
  input  logic [BW-1:0] cfg_blk,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic          cfg_src_area,
  input  logic          cfg_dst_area,
  input  logic          cfg_blk_irq_en,
  input  logic          req,
  output logic          ack,
  output logic          hold,
  output logic          busy,
  output logic          blk_end,
  output logic          irq_blk,
  output logic          irq_done,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);
  blkdma_st_e    st_q;
  logic          en_q, pend_q;
  logic [1:0]    size_q;
  logic          sinc_q, dinc_q, sarea_q, darea_q, birq_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] src_cur, dst_cur;
  logic [2:0]    bytes;

  // named internal events
  logic load, accept, elem_done, total_last, blk_last, fin_blk, fin_total;

  assign bytes     = size_bytes(size_q);
  assign load      = cfg_start && (st_q == ST_IDLE);
  assign accept    = (st_q == ST_IDLE) && en_q && pend_q;
  assign elem_done = (st_q == ST_WR) && bus_ready;
  assign fin_blk   = elem_done && blk_last;
  assign fin_total = elem_done && total_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      size_q  <= 2'b00;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      sarea_q <= 1'b0;
      darea_q <= 1'b0;
      birq_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      if (load) begin
        en_q    <= 1'b1;
        size_q  <= cfg_size;
        sinc_q  <= cfg_src_inc;
        dinc_q  <= cfg_dst_inc;
        sarea_q <= cfg_src_area;
        darea_q <= cfg_dst_area;
        birq_q  <= cfg_blk_irq_en;
      end else if (fin_total) begin
        en_q <= 1'b0;
      end

      if (load || accept) pend_q <= req;
      else if (req)       pend_q <= 1'b1;

      case (st_q)
        ST_IDLE: if (accept) st_q <= ST_RD;
        ST_RD: if (bus_ready) begin
          data_q <= bus_rdata;
          st_q   <= ST_WR;
        end
        ST_WR: if (bus_ready) st_q <= (fin_blk || fin_total) ? ST_IDLE : ST_RD;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  blkdma_addr #(.AW(AW)) i_src (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_src),
    .step(elem_done), .inc_en(sinc_q), .bytes(bytes),
    .restore(fin_blk && sarea_q), .cur(src_cur)
  );

  blkdma_addr #(.AW(AW)) i_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_dst),
    .step(elem_done), .inc_en(dinc_q), .bytes(bytes),
    .restore(fin_blk && darea_q), .cur(dst_cur)
  );

  blkdma_cnt #(.TW(TW), .BW(BW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .total_val(cfg_total),
    .blk_val(cfg_blk), .blk_start(accept), .step(elem_done), .bytes(bytes),
    .total_last(total_last), .blk_last(blk_last)
  );

  assign ack       = accept;
  assign hold      = (st_q != ST_IDLE);
  assign busy      = en_q;
  assign blk_end   = fin_blk;
  assign irq_blk   = fin_blk && birq_q;
  assign irq_done  = fin_total;
  assign bus_valid = hold;
  assign bus_write = (st_q == ST_WR);
  assign bus_addr  = (st_q == ST_WR) ? dst_cur : src_cur;
  assign bus_size  = size_q;
  assign bus_wdata = data_q;
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          hold,
  input logic          busy,
  input logic          blk_end,
  input logic          irq_blk,
  input logic          irq_done,
  input logic          bus_valid,
  input logic          bus_write,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr
);
  p_ack_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !hold);

  p_ack_opens_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> hold);

  p_release_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end || irq_done) |=> !hold);

  p_end_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> (bus_valid && bus_write && bus_ready));

  p_blk_irq_with_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_blk |-> blk_end);

  p_done_disables_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !busy);

  p_no_ack_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ack);

  p_stable_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));
endmodule

bind blkdma_seq blkdma_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .hold(hold), .busy(busy),
  .blk_end(blk_end), .irq_blk(irq_blk), .irq_done(irq_done),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_ready(bus_ready),
  .bus_addr(bus_addr)
);

// File: tb/test_blkdma_seq.sv
`timescale 1ns/1ps
module test_blkdma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_total = '0;
  logic [15:0] cfg_blk = '0;
  logic [1:0]  cfg_size = '0;
  logic        cfg_src_inc = 0, cfg_dst_inc = 0, cfg_src_area = 0, cfg_dst_area = 0;
  logic        cfg_blk_irq_en = 0, req = 0;
  logic        ack, hold, busy, blk_end, irq_blk, irq_done;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;

  int n_chk = 0, n_pass = 0;
  int wait_cfg = 0, wcnt = 0;
  int nw = 0, nr = 0, n_ack = 0;
  logic [31:0] w_addr [64];
  logic [31:0] w_data [64];
  logic [31:0] r_addr [64];
  logic        w_end [64];
  logic        w_bi [64];
  logic        w_done [64];

  always #5 clk = ~clk;

  blkdma_seq i_blkdma_seq (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_total(cfg_total), .cfg_blk(cfg_blk),
    .cfg_size(cfg_size), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_src_area(cfg_src_area), .cfg_dst_area(cfg_dst_area),
    .cfg_blk_irq_en(cfg_blk_irq_en), .req(req), .ack(ack), .hold(hold),
    .busy(busy), .blk_end(blk_end), .irq_blk(irq_blk), .irq_done(irq_done),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready)
  );

  // bus responder and event logger: ready decided at the falling edge, logged 1 ns later
  always @(negedge clk) begin
    if (bus_valid && rst_n) begin
      if (wcnt == 0) begin
        bus_ready = 1'b1;
        bus_rdata = ~bus_addr;
        wcnt = wait_cfg;
      end else begin
        bus_ready = 1'b0;
        wcnt = wcnt - 1;
      end
    end else begin
      bus_ready = 1'b0;
      wcnt = wait_cfg;
    end
    #1;
    if (ack) n_ack = n_ack + 1;
    if (bus_valid && bus_ready) begin
      if (bus_write && nw < 64) begin
        w_addr[nw] = bus_addr;
        w_data[nw] = bus_wdata;
        w_end[nw]  = blk_end;
        w_bi[nw]   = irq_blk;
        w_done[nw] = irq_done;
        nw = nw + 1;
      end else if (!bus_write && nr < 64) begin
        r_addr[nr] = bus_addr;
        nr = nr + 1;
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_pass, n_chk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act === exp) n_pass = n_pass + 1;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic clear_log();
    nw = 0; nr = 0; n_ack = 0;
  endtask

  task automatic cfg(input logic [31:0] s, input logic [31:0] d, input logic [31:0] tot,
                     input logic [15:0] blk, input logic [1:0] sz, input logic si, input logic di,
                     input logic sa, input logic da, input logic bie);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_total = tot; cfg_blk = blk; cfg_size = sz;
    cfg_src_inc = si; cfg_dst_inc = di; cfg_src_area = sa; cfg_dst_area = da;
    cfg_blk_irq_en = bie; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    for (int k = 0; k < 3000 && nw < n; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R3 hold after reset", 32'(hold), 0);
    chk("R2 bus_valid after reset", 32'(bus_valid), 0);
    chk("R2 ack after reset", 32'(ack), 0);
  endtask

  // word elements, both sides advance, two blocks of 3 use up the total
  task automatic t_basic();
    cfg(32'h1000, 32'h2000, 24, 3, 2'b10, 1, 1, 0, 0, 0);
    chk("R1 busy after start", 32'(busy), 1);
    clear_log(); pulse_req(); wait_writes(3);
    chk("R2 writes per block", nw, 3);
    chk("R2 reads per block", nr, 3);
    chk("R2 one ack per block", n_ack, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R4 word dst step", w_addr[i], 32'h2000 + 4*i);
      chk("R4 word src step", r_addr[i], 32'h1000 + 4*i);
      chk("R2 data copied", w_data[i], ~(32'h1000 + 4*i));
      chk("R8 end on last only", 32'(w_end[i]), 32'(i == 2));
      chk("R9 no irq when disabled", 32'(w_bi[i]), 0);
    end
    chk("R3 hold released", 32'(hold), 0);
    chk("R10 still busy", 32'(busy), 1);
    clear_log(); pulse_req(); wait_writes(3);
    for (int i = 0; i < 3; i++) begin
      chk("R7 dst continues", w_addr[i], 32'h200C + 4*i);
      chk("R7 src continues", r_addr[i], 32'h100C + 4*i);
    end
    chk("R10 done pulse on last write", 32'(w_done[2]), 1);
    chk("R10 busy cleared", 32'(busy), 0);
  endtask

  // byte elements, source is a block area, two wait states, block irq on
  task automatic t_src_area();
    wait_cfg = 2;
    cfg(32'h10, 32'h40, 6, 2, 2'b00, 1, 1, 1, 0, 1);
    clear_log();
    pulse_req(); wait_writes(2);
    pulse_req(); wait_writes(4);
    chk("R12 writes with wait states", nw, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 src restored", r_addr[i], 32'h10 + (i % 2));
      chk("R5 dst advances", w_addr[i], 32'h40 + i);
      chk("R12 data under wait", w_data[i], ~(32'h10 + (i % 2)));
      chk("R9 block irq", 32'(w_bi[i]), 32'(i % 2 == 1));
    end
    chk("R10 busy with bytes left", 32'(busy), 1);
    wait_cfg = 0;
  endtask

  // 16-bit elements, destination is a block area
  task automatic t_dst_area();
    cfg(32'h100, 32'h80, 100, 2, 2'b01, 1, 1, 0, 1, 0);
    clear_log();
    pulse_req(); wait_writes(2);
    pulse_req(); wait_writes(4);
    for (int i = 0; i < 4; i++) begin
      chk("R6 dst restored", w_addr[i], 32'h80 + 2*(i % 2));
      chk("R6 src advances", r_addr[i], 32'h100 + 2*i);
      chk("R9 irq disabled", 32'(w_bi[i]), 0);
    end
  endtask

  // source increment off
  task automatic t_noinc();
    cfg(32'h300, 32'h400, 12, 3, 2'b10, 0, 1, 0, 0, 0);
    clear_log(); pulse_req(); wait_writes(3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 fixed src", r_addr[i], 32'h300);
      chk("R4 dst step", w_addr[i], 32'h400 + 4*i);
    end
    chk("R10 busy cleared", 32'(busy), 0);
  endtask

  // total runs out in the middle of a block
  task automatic t_mid();
    cfg(32'h500, 32'h600, 8, 4, 2'b10, 1, 1, 0, 0, 0);
    clear_log(); pulse_req(); wait_writes(2);
    chk("R10 stops mid block", nw, 2);
    chk("R10 done pulse", 32'(w_done[1]), 1);
    chk("R10 no block end mid block", 32'(w_end[1]), 0);
    chk("R10 hold released", 32'(hold), 0);
    chk("R10 busy cleared", 32'(busy), 0);
    clear_log(); pulse_req();
    repeat (20) @(negedge clk);
    chk("R10 no ack when done", n_ack, 0);
    chk("R10 no bus when done", nw + nr, 0);
  endtask

  // request and restart attempt during a block
  task automatic t_pending();
    cfg(32'h700, 32'h800, 64, 2, 2'b10, 1, 1, 0, 0, 0);
    clear_log(); pulse_req();
    for (int k = 0; k < 50 && !hold; k++) @(negedge clk);
    req = 1'b1;
    cfg(32'hF00, 32'hE00, 4, 1, 2'b00, 0, 0, 1, 1, 1);
    req = 1'b0;
    wait_writes(4);
    chk("R11 latched request served", nw, 4);
    chk("R11 two acks", n_ack, 2);
    for (int i = 0; i < 4; i++) begin
      chk("R1 restart ignored dst", w_addr[i], 32'h800 + 4*i);
      chk("R1 restart ignored src", r_addr[i], 32'h700 + 4*i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    n_chk = n_chk + 1;
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_src_area();
    t_dst_area();
    t_noinc();
    t_mid();
    t_pending();
    report();
    $finish;
  end
endmodule